// File: doc/BRIEF.md
# Shared Linked-List Flit Store

One storage array holds the flits of several virtual channels. Cells are not tied to a channel. Each stored flit sits in a cell that also carries a link to the next cell of the same channel. The cells a channel owns therefore form a chain that runs from its oldest flit to its newest. Every cell that no channel owns sits on one spare chain. A write takes its cell from the front of that spare chain. A read gives the cell back to the front of the spare chain.

The write side presents a flit and a channel number and learns, in the same cycle, whether the flit was taken. The read side presents a channel number and sees, in the same cycle, the oldest flit of that channel together with a valid flag. The pop takes effect at the next clock edge.

A sliding admission limit stops any one channel from taking the whole array. A channel is always let in while it holds fewer than a reserved number of cells. Past that point it may grow only while its count stays below a shifted fraction of the spare count plus the reserve. When a read and an accepted write happen in the same cycle, the cell freed by the read goes straight to the write, and the spare chain is left untouched.

Top module: `lbuf_top`

## Requirements
- R1: After synchronous reset, `free_count` equals NUM_CELLS, every channel occupancy in `vc_occ` is 0, and a read on any channel returns `rd_valid` low.
- R2: Flits written to one channel are read back from that channel in the order they were written.
- R3: Channels are independent: interleaved writes to different channels come back per channel in each channel's own order, whatever the order in which the channels are read.
- R4: A write to channel v whose occupancy is c is accepted exactly when (c < RESV or c < (free_count >> FRAC_SHIFT) + RESV) and either free_count > 0 or a valid read happens in the same cycle. With the defaults RESV=2 and FRAC_SHIFT=1, a lone channel filled from reset takes exactly 7 flits.
- R5: A rejected write changes no occupancy and does not change `free_count`.
- R6: A read on a channel with occupancy 0 gives `rd_valid` low and changes no state.
- R7: An accepted write with no valid read lowers `free_count` by 1 and raises the writer's occupancy by 1. A valid read with no accepted write does the reverse for the read channel.
- R8: When a valid read and an accepted write happen in the same cycle, `free_count` stays the same, the read channel's occupancy drops by 1 and the write channel's occupancy rises by 1.
- R9: A channel holding a single flit that is read and written in the same cycle ends up holding exactly the new flit.
- R10: `free_count` plus the sum of all channel occupancies always equals NUM_CELLS. Draining every channel restores `free_count` to NUM_CELLS.
- R11: `rd_flit` shows the oldest flit of `rd_vc` in the same cycle that `rd_en` is high and `rd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_vc | input | VC_W | Channel of the write |
| wr_flit | input | FLIT_W | Flit to store |
| wr_ok | output | 1 | Write accepted this cycle |
| rd_en | input | 1 | Read request |
| rd_vc | input | VC_W | Channel to read |
| rd_valid | output | 1 | A flit is returned this cycle |
| rd_flit | output | FLIT_W | Oldest flit of the read channel |
| free_count | output | CNT_W | Cells on the spare chain |
| vc_occ | output | NUM_VC*CNT_W | Per-channel occupancy, channel v in bits v*CNT_W upward |

## Verification
A pop from one channel and an admitted push, to the same channel or to another, can land in one cycle. In that cycle the popped cell is handed straight to the push. The bench forces this overlap in two settings: between two different channels while the spare chain is partly used, and on a channel holding a single flit, where that flit's cell is both released and refilled. The bench judges each case by comparing the spare count, which must not move, and the later read-back order with a queue model kept in the bench.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

    // Sliding admission rule: the reserve is always granted; beyond it the
    // channel may grow only below a shifted share of the spare count.
    function automatic logic admit_rule(
        input int unsigned occ,
        input int unsigned spare,
        input int unsigned resv,
        input int unsigned shift
    );
        logic below_resv;
        logic below_slide;
        below_resv  = (occ < resv);
        below_slide = (occ < ((spare >> shift) + resv));
        return below_resv || below_slide;
    endfunction

    // Successor of a cell index in the reset-time spare chain.
    function automatic int unsigned chain_succ(input int unsigned idx);
        return idx + 1;
    endfunction

endpackage

// File: rtl/lbuf_admit.sv
module lbuf_admit #(
    parameter int CNT_W      = 5,
    parameter int RESV       = 2,
    parameter int FRAC_SHIFT = 1
) (
    input  logic [CNT_W-1:0] occ,
    input  logic [CNT_W-1:0] spare,
    output logic             ok
);
    import lbuf_pkg::*;

    generate
        if (RESV == 0 && FRAC_SHIFT == 0) begin : g_plain
            // no reserve, full spare share: grow while below the spare count
            assign ok = (occ < spare);
        end else begin : g_slide
            assign ok = admit_rule(int'(occ), int'(spare), RESV, FRAC_SHIFT);
        end
    endgenerate

endmodule

// File: rtl/lbuf_flitmem.sv
module lbuf_flitmem #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/lbuf_freelist.sv
module lbuf_freelist #(
    parameter int NUM_CELLS = 16,
    parameter int CELL_W    = 4,
    parameter int CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop,
    input  logic              push,
    input  logic [CELL_W-1:0] push_idx,
    input  logic [CELL_W:0]   head_succ,   // {null, idx} link held by the head cell
    output logic [CELL_W:0]   head,        // {null, idx}
    output logic [CNT_W-1:0]  count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            count <= CNT_W'(NUM_CELLS);
        end else begin
            if (push)     head <= {1'b0, push_idx};
            else if (pop) head <= head_succ;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/lbuf_top.sv
module lbuf_top #(
    parameter int NUM_VC     = 4,
    parameter int NUM_CELLS  = 16,
    parameter int FLIT_W     = 16,
    parameter int RESV       = 2,
    parameter int FRAC_SHIFT = 1,
    localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int CELL_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
    localparam int CNT_W  = $clog2(NUM_CELLS + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [VC_W-1:0]         wr_vc,
    input  logic [FLIT_W-1:0]       wr_flit,
    output logic                    wr_ok,
    input  logic                    rd_en,
    input  logic [VC_W-1:0]         rd_vc,
    output logic                    rd_valid,
    output logic [FLIT_W-1:0]       rd_flit,
    output logic [CNT_W-1:0]        free_count,
    output logic [NUM_VC*CNT_W-1:0] vc_occ
);
    import lbuf_pkg::*;

    typedef struct packed {
        logic              nul;
        logic [CELL_W-1:0] idx;
    } link_t;

    localparam link_t NULL_LINK = '{nul: 1'b1, idx: '0};

    // per-cell successor links, per-channel chain ends and occupancy
    link_t            succ_q [NUM_CELLS];
    link_t            head_q [NUM_VC];
    link_t            tail_q [NUM_VC];
    logic [CNT_W-1:0] occ_q  [NUM_VC];

    link_t            spare_head;
    logic [CNT_W-1:0] spare_cnt;

    logic              adm_ok, wr_fire, rd_fire, reuse, pop, push, link_old;
    logic [CELL_W-1:0] rcell, wcell;
    logic [CNT_W-1:0]  wr_occ, rd_occ;
    logic [NUM_VC-1:0] rd_hit, wr_hit;

    always_comb begin
        rd_occ   = occ_q[rd_vc];
        wr_occ   = occ_q[wr_vc];
        rcell    = head_q[rd_vc].idx;
        rd_fire  = rd_en && (rd_occ != '0);
        wr_fire  = wr_en && adm_ok && (!spare_head.nul || rd_fire);
        reuse    = wr_fire && rd_fire;
        wcell    = reuse ? rcell : spare_head.idx;
        pop      = wr_fire && !reuse;
        push     = rd_fire && !reuse;
        // append behind the old tail unless that tail is the cell being read out
        link_old = wr_fire && (wr_occ != '0)
                   && !(rd_fire && (rd_vc == wr_vc) && (wr_occ == CNT_W'(1)));
        for (int v = 0; v < NUM_VC; v++) begin
            rd_hit[v] = rd_fire && (rd_vc == VC_W'(v));
            wr_hit[v] = wr_fire && (wr_vc == VC_W'(v));
        end
    end

    lbuf_admit #(
        .CNT_W      (CNT_W),
        .RESV       (RESV),
        .FRAC_SHIFT (FRAC_SHIFT)
    ) u_admit (
        .occ   (wr_occ),
        .spare (spare_cnt),
        .ok    (adm_ok)
    );

    lbuf_freelist #(
        .NUM_CELLS (NUM_CELLS),
        .CELL_W    (CELL_W),
        .CNT_W     (CNT_W)
    ) u_spare (
        .clk       (clk),
        .rst       (rst),
        .pop       (pop),
        .push      (push),
        .push_idx  (rcell),
        .head_succ (succ_q[spare_head.idx]),
        .head      (spare_head),
        .count     (spare_cnt)
    );

    lbuf_flitmem #(
        .DEPTH (NUM_CELLS),
        .WIDTH (FLIT_W),
        .AW    (CELL_W)
    ) u_mem (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (wcell),
        .wdata (wr_flit),
        .raddr (rcell),
        .rdata (rd_flit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CELLS; i++) begin
                succ_q[i].nul <= (i == NUM_CELLS - 1);
                succ_q[i].idx <= CELL_W'(chain_succ(i));
            end
            for (int v = 0; v < NUM_VC; v++) begin
                head_q[v] <= NULL_LINK;
                tail_q[v] <= NULL_LINK;
                occ_q[v]  <= '0;
            end
        end else begin
            if (push)     succ_q[rcell] <= spare_head;
            if (link_old) succ_q[tail_q[wr_vc].idx] <= '{nul: 1'b0, idx: wcell};
            if (wr_fire)  succ_q[wcell] <= NULL_LINK;
            for (int v = 0; v < NUM_VC; v++) begin
                if (rd_hit[v]) begin
                    if (occ_q[v] == CNT_W'(1))
                        head_q[v] <= wr_hit[v] ? '{nul: 1'b0, idx: wcell} : NULL_LINK;
                    else
                        head_q[v] <= succ_q[rcell];
                end else if (wr_hit[v] && occ_q[v] == '0) begin
                    head_q[v] <= '{nul: 1'b0, idx: wcell};
                end
                if (wr_hit[v])
                    tail_q[v] <= '{nul: 1'b0, idx: wcell};
                else if (rd_hit[v] && occ_q[v] == CNT_W'(1))
                    tail_q[v] <= NULL_LINK;
                occ_q[v] <= occ_q[v] + CNT_W'(wr_hit[v]) - CNT_W'(rd_hit[v]);
            end
        end
    end

    assign wr_ok      = wr_fire;
    assign rd_valid   = rd_fire;
    assign free_count = spare_cnt;

    generate
        for (genvar g = 0; g < NUM_VC; g++) begin : g_occ
            assign vc_occ[g*CNT_W +: CNT_W] = occ_q[g];
        end
    endgenerate

endmodule

// File: rtl/lbuf_checker.sv
module lbuf_checker #(
    parameter int NUM_VC     = 4,
    parameter int NUM_CELLS  = 16,
    parameter int RESV       = 2,
    parameter int VC_W       = 2,
    parameter int CNT_W      = 5
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [VC_W-1:0]         wr_vc,
    input logic                    wr_ok,
    input logic                    rd_en,
    input logic [VC_W-1:0]         rd_vc,
    input logic                    rd_valid,
    input logic [CNT_W-1:0]        free_count,
    input logic [NUM_VC*CNT_W-1:0] vc_occ
);
    int unsigned held;
    logic [CNT_W-1:0] rd_occ, wr_occ;

    always_comb begin
        held = 0;
        for (int v = 0; v < NUM_VC; v++) held += int'(vc_occ[v*CNT_W +: CNT_W]);
        rd_occ = vc_occ[int'(rd_vc)*CNT_W +: CNT_W];
        wr_occ = vc_occ[int'(wr_vc)*CNT_W +: CNT_W];
    end

    AST_CELL_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        (held + int'(free_count)) == NUM_CELLS);                               // R10

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_occ == '0) |-> !rd_valid);                                // R6

    AST_RESERVE_HONOURED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_occ) < RESV && free_count != '0) |-> wr_ok);         // R4

    AST_SOLO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && !rd_valid) |=> free_count == $past(free_count) - 1'b1);      // R7

    AST_SOLO_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !wr_ok) |=> free_count == $past(free_count) + 1'b1);      // R7

    AST_PAIR_KEEPS_FREE: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && rd_valid) |=> $stable(free_count));                          // R8

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!wr_ok && !rd_valid) |=> ($stable(free_count) && $stable(vc_occ)));   // R5

endmodule

bind lbuf_top lbuf_checker #(
    .NUM_VC    (NUM_VC),
    .NUM_CELLS (NUM_CELLS),
    .RESV      (RESV),
    .VC_W      (VC_W),
    .CNT_W     (CNT_W)
) u_lbuf_checker (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_vc      (wr_vc),
    .wr_ok      (wr_ok),
    .rd_en      (rd_en),
    .rd_vc      (rd_vc),
    .rd_valid   (rd_valid),
    .free_count (free_count),
    .vc_occ     (vc_occ)
);

// File: tb/lbuf_top_bench.sv
module lbuf_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_VC     = 4;
    localparam int NUM_CELLS  = 16;
    localparam int FLIT_W     = 16;
    localparam int RESV       = 2;
    localparam int FRAC_SHIFT = 1;
    localparam int VC_W       = 2;
    localparam int CNT_W      = 5;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    wr_en = 1'b0;
    logic [VC_W-1:0]         wr_vc = '0;
    logic [FLIT_W-1:0]       wr_flit = '0;
    logic                    wr_ok;
    logic                    rd_en = 1'b0;
    logic [VC_W-1:0]         rd_vc = '0;
    logic                    rd_valid;
    logic [FLIT_W-1:0]       rd_flit;
    logic [CNT_W-1:0]        free_count;
    logic [NUM_VC*CNT_W-1:0] vc_occ;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int mq [NUM_VC][$];
    int mfree;

    lbuf_top #(
        .NUM_VC (NUM_VC), .NUM_CELLS (NUM_CELLS), .FLIT_W (FLIT_W),
        .RESV (RESV), .FRAC_SHIFT (FRAC_SHIFT)
    ) u_lbuf_top (
        .clk (clk), .rst (rst),
        .wr_en (wr_en), .wr_vc (wr_vc), .wr_flit (wr_flit), .wr_ok (wr_ok),
        .rd_en (rd_en), .rd_vc (rd_vc), .rd_valid (rd_valid), .rd_flit (rd_flit),
        .free_count (free_count), .vc_occ (vc_occ)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit good, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int occ_of(input int v);
        return int'(vc_occ[v*CNT_W +: CNT_W]);
    endfunction

    task automatic check_counts(input string req);
        chk(int'(free_count) == mfree, req, "free_count", int'(free_count), mfree);
        for (int v = 0; v < NUM_VC; v++)
            chk(occ_of(v) == mq[v].size(), req, $sformatf("occ vc%0d", v),
                occ_of(v), mq[v].size());
    endtask

    // one clock of traffic; called and returns at a falling edge
    task automatic step(input bit we, input int wv, input int wd,
                        input bit re, input int rv, input string req,
                        output bit accepted);
        bit exp_rv, exp_ok;
        int c;
        exp_rv = re && (mq[rv].size() != 0);
        c      = mq[wv].size();
        exp_ok = we && ((c < RESV) || (c < ((mfree >> FRAC_SHIFT) + RESV)))
                    && ((mfree > 0) || exp_rv);
        wr_en = we; wr_vc = VC_W'(wv); wr_flit = FLIT_W'(wd);
        rd_en = re; rd_vc = VC_W'(rv);
        #1;
        chk(wr_ok == exp_ok, req, "wr_ok", int'(wr_ok), int'(exp_ok));
        chk(rd_valid == exp_rv, req, "rd_valid", int'(rd_valid), int'(exp_rv));
        if (exp_rv)
            chk(int'(rd_flit) == mq[rv][0], "R11", "rd_flit", int'(rd_flit), mq[rv][0]);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        if (exp_rv) void'(mq[rv].pop_front());
        if (exp_ok) mq[wv].push_back(wd);
        if (exp_ok && !exp_rv) mfree--;
        if (exp_rv && !exp_ok) mfree++;
        check_counts(req);
        accepted = exp_ok;
    endtask

    task automatic t_reset();
        bit a;
        check_counts("R1");
        for (int v = 0; v < NUM_VC; v++) step(0, 0, 0, 1, v, "R1", a);
        chk(int'(free_count) == NUM_CELLS, "R1", "free after reset",
            int'(free_count), NUM_CELLS);
    endtask

    task automatic t_order();
        bit a;
        for (int i = 0; i < 3; i++) step(1, 1, 16'h1100 + i, 0, 0, "R2", a);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, "R2", a);
    endtask

    task automatic t_interleave();
        bit a;
        step(1, 0, 16'h0A01, 0, 0, "R3", a);
        step(1, 2, 16'h0B01, 0, 0, "R3", a);
        step(1, 0, 16'h0A02, 0, 0, "R3", a);
        step(1, 2, 16'h0B02, 0, 0, "R3", a);
        step(0, 0, 0, 1, 2, "R3", a);
        step(0, 0, 0, 1, 0, "R3", a);
        step(0, 0, 0, 1, 2, "R3", a);
        step(0, 0, 0, 1, 0, "R3", a);
    endtask

    task automatic t_empty_read();
        bit a;
        step(0, 0, 0, 1, 3, "R6", a);
        chk(rd_valid == 1'b0, "R6", "rd_valid after empty read", int'(rd_valid), 0);
    endtask

    task automatic t_hog();
        bit a;
        int got = 0;
        for (int i = 0; i < NUM_CELLS; i++) begin
            step(1, 0, 16'h2000 + i, 0, 0, "R4", a);
            if (a) got++;
            else break;
        end
        chk(got == 7, "R4", "lone channel accepted", got, 7);
        step(1, 0, 16'h2FFF, 0, 0, "R5", a);
        chk(a == 0, "R5", "second rejected write", int'(a), 0);
        step(1, 3, 16'h3001, 0, 0, "R4", a);
        chk(a == 1, "R4", "reserve write", int'(a), 1);
    endtask

    task automatic t_pair();
        bit a;
        int f0;
        f0 = mfree;
        step(1, 1, 16'h4001, 1, 0, "R8", a);
        chk(int'(free_count) == f0, "R8", "free over pair", int'(free_count), f0);
        step(1, 1, 16'h4002, 1, 0, "R8", a);
    endtask

    task automatic t_same_single();
        bit a;
        step(1, 3, 16'h5005, 1, 3, "R9", a);
        chk(occ_of(3) == 1, "R9", "single flit channel occ", occ_of(3), 1);
        step(0, 0, 0, 1, 3, "R9", a);
    endtask

    task automatic t_fill_and_drain();
        bit a;
        for (int v = 0; v < NUM_VC; v++)
            for (int i = 0; i < NUM_CELLS; i++) begin
                step(1, v, 16'h6000 + 16*v + i, 0, 0, "R4", a);
                if (!a) break;
            end
        for (int v = 0; v < NUM_VC; v++)
            while (mq[v].size() != 0) step(0, 0, 0, 1, v, "R10", a);
        chk(int'(free_count) == NUM_CELLS, "R10", "free after drain",
            int'(free_count), NUM_CELLS);
        for (int i = 0; i < 4; i++) step(1, 2, 16'h7000 + i, 0, 0, "R7", a);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 2, "R7", a);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        mfree = NUM_CELLS;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_order();
        t_interleave();
        t_empty_read();
        t_hog();
        t_pair();
        t_same_single();
        t_fill_and_drain();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule